// File: doc/BRIEF.md
# Reloadable Interval Timer with Snapshot Readback

This block is a periodic interval timer that sits behind a byte-wide register interface on a small bus slave. Software loads a 22-bit terminal value through three byte registers and sets a count-enable bit. The counter then climbs from zero on a 33 MHz tick. When it reaches the terminal value it returns to zero, and each return marks one period. If the interrupt-enable bit is set, a period end raises a level interrupt. That interrupt stays high until software clears the interrupt-enable bit, and setting the bit again arms it for the next period.

The live count is read through a holding register. A read of readback byte 0 copies the whole count into the holding register, and readback bytes 1 to 3 then return slices of that copy. Readback bytes 0 to 2 each carry a 6-bit group of the count in a packed layout. A strap input states whether the bus clock runs at 66 MHz. When it does, the bus clock is halved to form the tick, so the count rate does not change.

Top module: `ivt_timer`

## Requirements
- R1: With `strap_66` low the counter advances on every clock while counting is enabled. With `strap_66` high it advances on every second clock, and the first advance comes two clocks after counting is enabled.
- R2: The count starts at zero and rises by one per tick. On a tick where the count is greater than or equal to the terminal value, the count returns to zero. A period is therefore terminal+1 ticks, and lowering the terminal below the live count forces a return to zero on the next tick.
- R3: A write to address 0 loads terminal bits 7:0 and a write to address 1 loads terminal bits 15:8. A write to address 2 loads terminal bits 21:16 from data bits 5:0, and data bits 7:6 are ignored.
- R4: Address 4 is the control register. Bit 0 is count-enable and bit 1 is interrupt-enable, both 0 after reset. A read returns both bits in those positions, with bits 7:2 read as zero.
- R5: While count-enable is 0 the counter is held at zero. A terminal value written while counting is disabled takes effect when counting resumes.
- R6: A read of address 0 copies the live count into the holding register on that clock. Every read returns its data on `bus_rdata` on the clock after the one that samples `bus_rd`, and the data holds until the next read. Reads of addresses 1 to 3 return slices of the last copy, whatever the counter has done since.
- R7: Readback byte k (address k, for k = 0, 1, 2) carries count bits 6k+4 to 6k in byte bits 4:0 and count bit 6k+5 in byte bit 6. Byte bits 5 and 7 read as zero.
- R8: Readback byte 3 (address 3) carries count bits 21:18 in byte bits 3:0, with bits 7:4 read as zero.
- R9: `irq` goes high on the clock after a period end that occurs while interrupt-enable is 1. It stays high as long as interrupt-enable stays 1.
- R10: `irq` is low on the clock after interrupt-enable is seen at 0. Period ends that occur while interrupt-enable is 0 leave no pending interrupt behind.
- R11: Reads of addresses 5 to 7 return zero. Writes to addresses 3, 5, 6 and 7 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, 33 MHz or 66 MHz |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strap_66 | input | 1 | High when the bus clock is 66 MHz; the tick is then the clock halved |
| bus_wr | input | 1 | Write strobe for one clock |
| bus_rd | input | 1 | Read strobe for one clock |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the clock after the read strobe |
| irq | output | 1 | Level interrupt for a period end |

## Verification
The bench lets the counter run long enough to set count bit 17. A design that places group bit 5 in byte bit 5, or that drops it, then returns a wrong byte 2. The bench lowers the terminal below the live count while the timer runs, and a design that compares for equality only would count on toward the 22-bit limit and never wrap. It writes terminal byte 2 with bits 7:6 set and a small value below them. A design that kept those bits would see a huge terminal and stop producing interrupts. Further checks cover a byte 1 read taken long after the byte 0 read, which catches readback bytes that follow the live count, and dropping interrupt-enable between periods, which catches an interrupt that is latched while disarmed.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CNT_W   = 22;
  localparam int BYTE_W  = 8;
  localparam int GRP_W   = 6;
  localparam int ADDR_W  = 3;
  localparam int NUM_TB  = (CNT_W + BYTE_W - 1) / BYTE_W;
  localparam int NUM_RB  = (CNT_W + GRP_W - 1) / GRP_W;
  localparam int CTL_CEN = 0;
  localparam int CTL_IEN = 1;
  localparam logic [ADDR_W-1:0] ADDR_CTL = ADDR_W'(4);

  typedef logic [BYTE_W-1:0] byte_t;

  // Full 6-bit group: low five bits in place, bit 5 moved to byte bit 6.
  function automatic byte_t pack_full(input logic [GRP_W-1:0] g);
    byte_t b;
    b = '0;
    b[4:0] = g[4:0];
    b[6]   = g[5];
    return b;
  endfunction
endpackage

// File: rtl/ivt_rst_sync.sv
module ivt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/ivt_tick_gen.sv
module ivt_tick_gen #(
  parameter bit HAS_DIV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cen,
  input  logic strap_66,
  output logic tick
);
  generate
    if (HAS_DIV) begin : g_div
      logic phase_q, phase_d;

      always_comb begin
        phase_d = cen ? ~phase_q : 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
      end

      assign tick = ~strap_66 | phase_q;
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
  parameter int CNT_W = ivt_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cen,
  input  logic             tick,
  input  logic [CNT_W-1:0] term,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ld;
  logic             at_end;

  always_comb begin
    at_end = (cnt_q >= term);
    wrap   = cen & tick & at_end;
    cnt_ld = ~cen | tick;
    if (!cen)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ien,
  input  logic wrap,
  output logic irq
);
  logic irq_q, irq_d;

  always_comb begin
    if (!ien)      irq_d = 1'b0;
    else if (wrap) irq_d = 1'b1;
    else           irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int CNT_W = ivt_pkg::CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  term,
  output logic              cen,
  output logic              ien,
  output logic [CNT_W-1:0]  snap,
  output logic [BYTE_W-1:0] bus_rdata
);
  localparam int TB = (CNT_W + BYTE_W - 1) / BYTE_W;
  localparam int RB = (CNT_W + GRP_W - 1) / GRP_W;

  // terminal byte lanes
  logic [CNT_W-1:0] term_q;

  generate
    for (genvar k = 0; k < TB; k++) begin : g_lane
      localparam int LO = k * BYTE_W;
      localparam int W  = (CNT_W - LO < BYTE_W) ? (CNT_W - LO) : BYTE_W;
      logic lane_we;
      assign lane_we = bus_wr && (bus_addr == ADDR_W'(k));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       term_q[LO +: W] <= '0;
        else if (lane_we) term_q[LO +: W] <= bus_wdata[W-1:0];
      end
    end
  endgenerate

  // control register
  logic cen_q, ien_q, ctl_we;
  assign ctl_we = bus_wr && (bus_addr == ADDR_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cen_q <= 1'b0;
      ien_q <= 1'b0;
    end else if (ctl_we) begin
      cen_q <= bus_wdata[CTL_CEN];
      ien_q <= bus_wdata[CTL_IEN];
    end
  end

  // snapshot register
  logic [CNT_W-1:0] snap_q;
  logic             snap_ld;
  assign snap_ld = bus_rd && (bus_addr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap_q <= '0;
    else if (snap_ld) snap_q <= cnt;
  end

  // packed readback views
  byte_t live_pk [RB];
  byte_t snap_pk [RB];

  generate
    for (genvar k = 0; k < RB; k++) begin : g_pack
      localparam int LO = k * GRP_W;
      localparam int W  = (CNT_W - LO < GRP_W) ? (CNT_W - LO) : GRP_W;
      if (W == GRP_W) begin : g_full
        assign live_pk[k] = pack_full(cnt[LO +: GRP_W]);
        assign snap_pk[k] = pack_full(snap_q[LO +: GRP_W]);
      end else begin : g_part
        assign live_pk[k] = BYTE_W'(cnt[LO +: W]);
        assign snap_pk[k] = BYTE_W'(snap_q[LO +: W]);
      end
    end
  endgenerate

  // read data
  byte_t rdata_q, rdata_d;

  always_comb begin
    rdata_d = '0;
    if (bus_addr == ADDR_CTL) begin
      rdata_d[CTL_CEN] = cen_q;
      rdata_d[CTL_IEN] = ien_q;
    end else begin
      for (int k = 0; k < RB; k++) begin
        if (bus_addr == ADDR_W'(k)) rdata_d = (k == 0) ? live_pk[0] : snap_pk[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign term      = term_q;
  assign cen       = cen_q;
  assign ien       = ien_q;
  assign snap      = snap_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_66,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  logic             rst_s_n;
  logic             tick, wrap, cen, ien;
  logic [CNT_W-1:0] cnt, term, snap;

  ivt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  ivt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt),
    .term(term), .cen(cen), .ien(ien), .snap(snap), .bus_rdata(bus_rdata)
  );

  ivt_tick_gen #(.HAS_DIV(1'b1)) u_tick (
    .clk(clk), .rst_n(rst_s_n), .cen(cen), .strap_66(strap_66), .tick(tick)
  );

  ivt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .cen(cen), .tick(tick), .term(term),
    .cnt(cnt), .wrap(wrap)
  );

  ivt_irq u_irq (
    .clk(clk), .rst_n(rst_s_n), .ien(ien), .wrap(wrap), .irq(irq)
  );
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk
  import ivt_pkg::*;
(
  input logic              clk,
  input logic              rst_s_n,
  input logic              strap_66,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tick,
  input logic              cen,
  input logic              ien,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  term,
  input logic [CNT_W-1:0]  snap
);
  p_div_half_r1: assert property (@(posedge clk) disable iff (!rst_s_n)
    (strap_66 && $past(strap_66) && cen && $past(cen) && $past(tick)) |-> !tick);

  p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cen && tick && cnt >= term) |=> cnt == '0);

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cen && tick && cnt < term) |=> cnt == $past(cnt) + CNT_W'(1));

  p_hold_zero_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !cen |=> cnt == '0);

  p_snap_take_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && bus_addr == '0) |=> snap == $past(cnt));

  p_snap_keep_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(bus_rd && bus_addr == '0) |=> $stable(snap));

  p_grp_spare_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && bus_addr < ADDR_W'(3)) |=> (bus_rdata[5] == 1'b0 && bus_rdata[7] == 1'b0));

  p_top_spare_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && bus_addr == ADDR_W'(3)) |=> bus_rdata[7:4] == 4'h0);

  p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ien && cen && tick && cnt >= term) |=> irq);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (irq && ien) |=> irq);

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !ien |=> !irq);

  p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_s_n)
    (bus_rd && bus_addr > ADDR_CTL) |=> bus_rdata == '0);
endmodule

bind ivt_timer ivt_timer_chk u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .strap_66(strap_66), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq(irq), .tick(tick),
  .cen(cen), .ien(ien), .cnt(cnt), .term(term), .snap(snap)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
  logic       clk;
  logic       rst_n;
  logic       strap_66;
  logic       bus_wr, bus_rd;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  ivt_timer u0 (
    .clk(clk), .rst_n(rst_n), .strap_66(strap_66), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural model built from the requirements
  logic [21:0] m_cnt, m_term, m_snap;
  logic        m_cen, m_ien, m_irq, m_ph;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_term = '0; m_snap = '0;
      m_cen = 0; m_ien = 0; m_irq = 0; m_ph = 0;
    end else begin
      logic t, w;
      t = !strap_66 || m_ph;
      if (bus_rd && bus_addr == 3'd0) m_snap = m_cnt;
      w = m_cen && t && (m_cnt >= m_term);
      if (!m_ien) m_irq = 0;
      else if (w) m_irq = 1;
      if (!m_cen) m_cnt = '0;
      else if (t) m_cnt = w ? 22'd0 : m_cnt + 22'd1;
      m_ph = m_cen ? !m_ph : 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: m_term[7:0]   = bus_wdata;
          3'd1: m_term[15:8]  = bus_wdata;
          3'd2: m_term[21:16] = bus_wdata[5:0];
          3'd4: begin m_cen = bus_wdata[0]; m_ien = bus_wdata[1]; end
          default: ;
        endcase
      end
    end
  end

  function automatic logic [7:0] exp_byte(input logic [2:0] a, input logic [21:0] s,
                                          input logic ce, input logic ie);
    logic [5:0] g;
    if (a <= 3'd2) begin
      g = 6'((s >> (6 * a)) & 22'h3F);
      return {1'b0, g[5], 1'b0, g[4:0]};
    end
    if (a == 3'd3) return {4'h0, s[21:18]};
    if (a == 3'd4) return {6'h00, ie, ce};
    return 8'h00;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input string req);
    logic [7:0] e;
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    e = exp_byte(a, m_snap, m_cen, m_ien);
    n_tests++;
    if (bus_rdata !== e) begin
      n_fail++;
      $display("FAIL %s read addr %0d: got %h expected %h", req, a, bus_rdata, e);
    end
  endtask

  task automatic irq_chk(input string req);
    n_tests++;
    if (irq !== m_irq) begin
      n_fail++;
      $display("FAIL %s irq: got %b expected %b", req, irq, m_irq);
    end
  endtask

  task automatic rd_all(input string req);
    for (int a = 0; a < 4; a++) rd_chk(3'(a), req);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'h1D5EED);
    rst_n = 0; strap_66 = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    idle(4);
    rst_n = 1;
    idle(5);

    // reset state
    irq_chk("R9 reset");
    rd_chk(3'd4, "R4 reset");
    rd_chk(3'd0, "R5 reset");

    // basic counting, strap low
    wr(3'd0, 8'd40); wr(3'd1, 8'd0); wr(3'd2, 8'd0);
    wr(3'd4, 8'h01);
    rd_chk(3'd4, "R4 cen");
    idle(17);
    rd_all("R1 R7 R8");
    idle(30);
    rd_chk(3'd0, "R2 wrap");

    // snapshot held while counter moves
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    idle(300);
    rd_chk(3'd0, "R6 take");
    idle(25);
    rd_chk(3'd1, "R6 hold");
    rd_chk(3'd2, "R6 hold");

    // disable holds zero, new terminal while disabled
    wr(3'd4, 8'h00);
    idle(3);
    rd_chk(3'd0, "R5 hold");
    wr(3'd0, 8'd6); wr(3'd1, 8'd0);
    wr(3'd4, 8'h03);
    idle(8);
    irq_chk("R9 set");
    rd_chk(3'd0, "R5 new term");
    idle(10);
    irq_chk("R9 hold");

    // interrupt acknowledge by dropping the enable
    wr(3'd4, 8'h01);
    idle(1);
    irq_chk("R10 clear");
    idle(20);
    irq_chk("R10 no latch");
    wr(3'd4, 8'h03);
    irq_chk("R10 rearm");
    idle(10);
    irq_chk("R9 next period");
    wr(3'd4, 8'h01);

    // lowering the terminal below the live count
    wr(3'd0, 8'hE8); wr(3'd1, 8'h03);
    idle(500);
    wr(3'd0, 8'd100); wr(3'd1, 8'd0);
    idle(3);
    rd_chk(3'd0, "R2 lowered");

    // byte 2 upper bits ignored
    wr(3'd4, 8'h00);
    wr(3'd0, 8'd3); wr(3'd1, 8'd0); wr(3'd2, 8'hC0);
    wr(3'd4, 8'h03);
    idle(6);
    irq_chk("R3 byte2 mask");
    rd_chk(3'd0, "R3 byte2 mask");

    // unmapped addresses
    wr(3'd3, 8'hFF); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
    rd_chk(3'd4, "R11 writes ignored");
    rd_chk(3'd5, "R11"); rd_chk(3'd6, "R11"); rd_chk(3'd7, "R11");
    idle(3);
    rd_chk(3'd0, "R11 count unaffected");

    // divide by two
    wr(3'd4, 8'h00);
    strap_66 = 1;
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF); wr(3'd2, 8'h3F);
    wr(3'd4, 8'h01);
    idle(21);
    rd_chk(3'd0, "R1 div2");
    idle(4);
    rd_chk(3'd0, "R1 div2 odd");
    wr(3'd4, 8'h00);
    strap_66 = 0;

    // long run reaching count bit 17
    wr(3'd4, 8'h01);
    idle(140000);
    rd_all("R7 R8 long");

    // random mix
    wr(3'd4, 8'h00); wr(3'd1, 8'd0); wr(3'd2, 8'd0);
    for (int i = 0; i < 400; i++) begin
      int op;
      op = int'($urandom % 6);
      case (op)
        0: wr(3'd4, 8'($urandom % 4));
        1: wr(3'd0, 8'($urandom % 32));
        2: rd_chk(3'($urandom % 8), "R6 R7 R11 random");
        3: idle(int'($urandom % 16));
        4: rd_all("R6 R7 R8 random");
        default: irq_chk("R9 R10 random");
      endcase
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule